// File: doc/BRIEF.md
# Sector Test Pattern Generator and Checker

This block sits beside a block storage controller in a test harness. For a write command it produces a stream of 128-bit words in a chosen pattern, covering a run of 512-byte sectors. For a read command it takes the returned words and compares each one with the same pattern, built again from the command's start sector. It keeps a running count of the bytes moved. Any mismatch sets a sticky failure flag. The first mismatch of a command also freezes a snapshot of the expected word, the word that arrived, and the word's absolute byte address, so that software can inspect them later.

A command is a one-cycle pulse on `cmd_start` together with a direction, a pattern code, a 48-bit start sector and a 48-bit sector count. Each sector holds 32 words. Both data paths use valid/ready handshakes, and a word moves on a clock edge where valid and ready are both high. On the write path the sink may hold `wr_ready` low for any number of cycles. While it does, `wr_valid` stays high and `wr_data` stays unchanged. On the read path the source may hold `rd_valid` low at any time. `rd_ready` is high for the whole of a read command and low at every other time. The pattern, the word count and the byte count move forward only on an accepted word.

Top module: `sector_pattern_engine`

## Requirements
- R1: Pattern code 000 (increment) gives a word whose 32-bit lane i (bits 32i+31..32i) equals B+i modulo 2^32. For the first word, B is the start sector times 128. B grows by 4 with each accepted word.
- R2: Pattern code 001 (decrement) gives lane i the bitwise inverse of B+i, with B defined as in R1.
- R3: Pattern code 010 gives all-zero words and code 011 gives all-one words. The unused codes 101, 110 and 111 give all-zero words.
- R4: Pattern code 100 (LFSR) gives each lane its own 32-bit register.
  - Seed: lane i starts at the low 32 bits of the start sector XOR (0x9E3779B9 times (i+1)) modulo 2^32. A seed of zero is replaced by 1.
  - Step: after each accepted word the register becomes s>>1 when s[0] is 0, and (s>>1) XOR 0x80200003 when s[0] is 1.
- R5: The pattern restarts from the start sector at every accepted command. A read of a region with the same pattern and start sector therefore expects exactly the words that a write of that region produced.
- R6: A command moves exactly 32 words per sector. `busy` rises in the cycle after the accepting edge and falls after the edge that accepts the last word. A sector count of 0 leaves `busy` low.
- R7: `bytes_done` is cleared when a command is accepted. It grows by 16 on each accepted word and can be read while a command is running.
- R8: `verify_fail` rises after the first read word that differs from the expected word. It stays high until the next accepted command.
- R9: On the first mismatch of a command, `fail_exp`, `fail_got` and `fail_byte_addr` capture the expected word, the received word, and the start sector times 512 plus the bytes already done. They then hold those values while later mismatches arrive.
- R10: An accepted command clears `verify_fail` and sets all three snapshot outputs to zero.
- R11: `wr_valid` is high only during a write command and `rd_ready` only during a read command. While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_data` stays unchanged.
- R12: A `cmd_start` pulse while `busy` is high is ignored. The running command's data, count and length are unaffected.
- R13: After reset, `busy`, `wr_valid`, `rd_ready`, `verify_fail` and `bytes_done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle command request, accepted only while idle |
| cmd_read | input | 1 | 1: check read data, 0: generate write data |
| cmd_pattern | input | 3 | Pattern code (R1 to R4) |
| cmd_sector | input | 48 | Start sector, in 512-byte units |
| cmd_count | input | 48 | Transfer length, in 512-byte units |
| busy | output | 1 | A command is running |
| wr_valid | output | 1 | Write word available |
| wr_ready | input | 1 | Sink accepts the write word |
| wr_data | output | 128 | Generated write word |
| rd_valid | input | 1 | Read word available |
| rd_ready | output | 1 | Block accepts the read word |
| rd_data | input | 128 | Returned read word |
| bytes_done | output | 57 | Bytes moved in the current command |
| verify_fail | output | 1 | Sticky mismatch flag |
| fail_exp | output | 128 | Expected word at the first mismatch |
| fail_got | output | 128 | Received word at the first mismatch |
| fail_byte_addr | output | 57 | Absolute byte address of the first mismatch |

## Verification
The assertions check the following on every cycle:
- `wr_valid` and `rd_ready` are never high at the same time.
- A stalled write word holds its value, and `wr_valid` stays high during the stall.
- `bytes_done` grows by 16 on each accepted word.
- `verify_fail` is sticky, and the snapshot stays frozen after the first mismatch.
- A command accepted while the failure flag is set clears it.
- A start pulse during a running command leaves the word count unchanged.

Only the bench's scenarios can show that each pattern code produces the right values, including the per-lane LFSR sequence and its seeds. The same holds for the claim that a read rebuilds the written stream from its start sector. The bench scenarios also check the exact snapshot contents and address for a corrupted word when a second corruption follows it, and the total length of a command.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int WORD_W     = 128;
  localparam int LANE_W     = 32;
  localparam int SECT_W     = 48;
  localparam int SECT_BYTES = 512;
  localparam int SECT_SHIFT = $clog2(SECT_BYTES);
  localparam int BYTE_W     = SECT_W + SECT_SHIFT;

  typedef enum logic [2:0] {
    PAT_INC  = 3'b000,
    PAT_DEC  = 3'b001,
    PAT_ZERO = 3'b010,
    PAT_ONE  = 3'b011,
    PAT_LFSR = 3'b100
  } pat_e;

  localparam logic [LANE_W-1:0] LFSR_MASK = 32'h8020_0003;
  localparam logic [LANE_W-1:0] SEED_MUL  = 32'h9E37_79B9;

  function automatic logic [LANE_W-1:0] lfsr_adv(input logic [LANE_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction

  function automatic logic [LANE_W-1:0] lane_seed(input logic [LANE_W-1:0] a, input int lane);
    logic [LANE_W-1:0] s;
    s = a ^ (SEED_MUL * LANE_W'(lane + 1));
    return (s == '0) ? LANE_W'(1) : s;
  endfunction
endpackage

// File: rtl/spg_pattern.sv
module spg_pattern
  import spg_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [2:0]        sel,
  input  logic [SECT_W-1:0] start_sector,
  output logic [W-1:0]      data
);
  localparam int LANES      = W / LANE_W;
  localparam int LANE_SHIFT = $clog2(SECT_BYTES / (LANE_W / 8));

  logic [LANE_W-1:0] base_q;
  logic [2:0]        sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= PAT_ZERO;
    end else if (load) begin
      base_q <= LANE_W'(start_sector << LANE_SHIFT);
      sel_q  <= sel;
    end else if (step) begin
      base_q <= base_q + LANE_W'(LANES);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lfsr_q;
    logic [LANE_W-1:0] count_v;

    assign count_v = base_q + LANE_W'(i);

    always_ff @(posedge clk) begin
      if (!rst_n)    lfsr_q <= LANE_W'(1);
      else if (load) lfsr_q <= lane_seed(start_sector[LANE_W-1:0], i);
      else if (step) lfsr_q <= lfsr_adv(lfsr_q);
    end

    always_comb begin
      unique case (sel_q)
        PAT_INC:  data[i*LANE_W +: LANE_W] = count_v;
        PAT_DEC:  data[i*LANE_W +: LANE_W] = ~count_v;
        PAT_ONE:  data[i*LANE_W +: LANE_W] = '1;
        PAT_LFSR: data[i*LANE_W +: LANE_W] = lfsr_q;
        default:  data[i*LANE_W +: LANE_W] = '0;
      endcase
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0); // R4
  end
endmodule

// File: rtl/spg_ctl.sv
module spg_ctl
  import spg_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic [SECT_W-1:0] count,
  input  logic              wr_ready,
  input  logic              rd_valid,
  output logic              accept,
  output logic              fire_wr,
  output logic              fire_rd,
  output logic              busy,
  output logic              wr_valid,
  output logic              rd_ready,
  output logic [BYTE_W-1:0] bytes
);
  localparam int WBYTES = W / 8;
  localparam int WPS_LG = $clog2(SECT_BYTES / WBYTES);
  localparam int REM_W  = SECT_W + WPS_LG;

  logic [REM_W-1:0] remain_q;
  logic             busy_q;
  logic             rd_mode_q;
  logic             fire;

  assign accept   = start && !busy_q;
  assign wr_valid = busy_q && !rd_mode_q;
  assign rd_ready = busy_q && rd_mode_q;
  assign fire_wr  = wr_valid && wr_ready;
  assign fire_rd  = rd_valid && rd_ready;
  assign fire     = fire_wr || fire_rd;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q  <= '0;
      busy_q    <= 1'b0;
      rd_mode_q <= 1'b0;
      bytes     <= '0;
    end else if (accept) begin
      remain_q  <= {count, {WPS_LG{1'b0}}};
      busy_q    <= (count != '0);
      rd_mode_q <= is_read;
      bytes     <= '0;
    end else if (fire) begin
      remain_q <= remain_q - REM_W'(1);
      bytes    <= bytes + BYTE_W'(WBYTES);
      if (remain_q == REM_W'(1)) busy_q <= 1'b0;
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !fire |=> remain_q == $past(remain_q)); // R12
endmodule

// File: rtl/spg_verify.sv
module spg_verify
  import spg_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              check,
  input  logic [W-1:0]      exp_word,
  input  logic [W-1:0]      got_word,
  input  logic [BYTE_W-1:0] byte_addr,
  output logic              fail,
  output logic [W-1:0]      exp_snap,
  output logic [W-1:0]      got_snap,
  output logic [BYTE_W-1:0] addr_snap
);
  logic miss;
  assign miss = check && (exp_word != got_word);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fail      <= 1'b0;
      exp_snap  <= '0;
      got_snap  <= '0;
      addr_snap <= '0;
    end else if (miss && !fail) begin
      fail      <= 1'b1;
      exp_snap  <= exp_word;
      got_snap  <= got_word;
      addr_snap <= byte_addr;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clear |=> fail); // R8
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clear |=> $stable(exp_snap) && $stable(got_snap) && $stable(addr_snap)); // R9
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    check && !clear && !fail && (exp_word != got_word) |=> fail && addr_snap == $past(byte_addr)); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !fail); // R10
endmodule

// File: rtl/sector_pattern_engine.sv
module sector_pattern_engine
  import spg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_read,
  input  logic [2:0]        cmd_pattern,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic [SECT_W-1:0] cmd_count,
  output logic              busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [WORD_W-1:0] rd_data,
  output logic [BYTE_W-1:0] bytes_done,
  output logic              verify_fail,
  output logic [WORD_W-1:0] fail_exp,
  output logic [WORD_W-1:0] fail_got,
  output logic [BYTE_W-1:0] fail_byte_addr
);
  logic              accept, fire_wr, fire_rd;
  logic [WORD_W-1:0] pat_word;
  logic [SECT_W-1:0] sector_q;
  logic [BYTE_W-1:0] word_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)      sector_q <= '0;
    else if (accept) sector_q <= cmd_sector;
  end

  assign word_addr = {sector_q, {SECT_SHIFT{1'b0}}} + bytes_done;
  assign wr_data   = pat_word;

  spg_ctl #(.W(WORD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .is_read(cmd_read),
    .count(cmd_count), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .accept(accept), .fire_wr(fire_wr), .fire_rd(fire_rd), .busy(busy),
    .wr_valid(wr_valid), .rd_ready(rd_ready), .bytes(bytes_done)
  );

  spg_pattern #(.W(WORD_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(fire_wr || fire_rd),
    .sel(cmd_pattern), .start_sector(cmd_sector), .data(pat_word)
  );

  spg_verify #(.W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(accept), .check(fire_rd),
    .exp_word(pat_word), .got_word(rd_data), .byte_addr(word_addr),
    .fail(verify_fail), .exp_snap(fail_exp), .got_snap(fail_got),
    .addr_snap(fail_byte_addr)
  );

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_ready)); // R11
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_data)); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_wr || fire_rd) |=> bytes_done == $past(bytes_done) + BYTE_W'(16)); // R7
endmodule

// File: tb/test_sector_pattern_engine.sv
module test_sector_pattern_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_read = 1'b0;
  logic [2:0] cmd_pattern = 3'b000;
  logic [47:0] cmd_sector = '0, cmd_count = '0;
  logic busy, wr_valid, rd_ready, verify_fail;
  logic wr_ready = 1'b1, rd_valid = 1'b0;
  logic [127:0] wr_data, rd_data = '0, fail_exp, fail_got;
  logic [56:0] bytes_done, fail_byte_addr;

  always #10 clk = ~clk;

  sector_pattern_engine i_sector_pattern_engine (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_pattern(cmd_pattern), .cmd_sector(cmd_sector), .cmd_count(cmd_count),
    .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bytes_done(bytes_done), .verify_fail(verify_fail), .fail_exp(fail_exp),
    .fail_got(fail_got), .fail_byte_addr(fail_byte_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [127:0] exp_q[$];
  int mon_cnt = 0;
  bit mon_tag_dec = 0;
  string mon_req = "R1";
  bit bp_en = 0;
  int bp_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] m_step(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  function automatic logic [31:0] m_seed(input logic [31:0] a, input int i);
    logic [31:0] s;
    s = a ^ (32'h9E37_79B9 * (i + 1));
    return (s == 0) ? 32'd1 : s;
  endfunction

  task automatic build(input logic [2:0] p, input logic [47:0] sec, input int words, ref logic [127:0] q[$]);
    logic [31:0] b, lf[4];
    logic [127:0] w;
    b = 32'(sec << 7);
    for (int i = 0; i < 4; i++) lf[i] = m_seed(sec[31:0], i);
    for (int k = 0; k < words; k++) begin
      for (int i = 0; i < 4; i++) begin
        case (p)
          3'b000:  w[i*32 +: 32] = b + i;
          3'b001:  w[i*32 +: 32] = ~(b + i);
          3'b011:  w[i*32 +: 32] = '1;
          3'b100:  w[i*32 +: 32] = lf[i];
          default: w[i*32 +: 32] = '0;
        endcase
        lf[i] = m_step(lf[i]);
      end
      b = b + 4;
      q.push_back(w);
    end
  endtask

  // monitor: pop and compare accepted write words, then drive next ready
  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      if (exp_q.size() == 0) chk(0, {mon_req, " extra write word"}, wr_data, '0);
      else begin
        logic [127:0] e;
        e = exp_q.pop_front();
        chk(wr_data == e, {mon_req, " write word"}, wr_data, e);
      end
      chk(bytes_done == 57'(16 * mon_cnt), "R7 running count", 128'(bytes_done), 128'(16 * mon_cnt));
      mon_cnt++;
    end
    wr_ready = bp_en ? ((bp_cnt % 3) != 1) : 1'b1;
    bp_cnt++;
  end

  task automatic issue(input bit rd, input logic [2:0] p, input logic [47:0] sec, input logic [47:0] cnt);
    @(negedge clk);
    cmd_read = rd; cmd_pattern = p; cmd_sector = sec; cmd_count = cnt;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic do_write(input string req, input logic [2:0] p, input logic [47:0] sec,
                          input logic [47:0] cnt, input bit bp, input bit intrude);
    build(p, sec, int'(cnt) * 32, exp_q);
    mon_req = req; mon_cnt = 0; bp_en = bp;
    issue(0, p, sec, cnt);
    chk(busy == 1'b1, "R6 busy after accept", 128'(busy), 128'(1));
    if (intrude) begin
      repeat (5) @(negedge clk);
      cmd_read = 1'b1; cmd_pattern = 3'b011; cmd_sector = 48'h77; cmd_count = 48'd9;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(exp_q.size() == 0, {req, " R6 word total"}, 128'(exp_q.size()), 0);
    chk(bytes_done == 57'(cnt) * 57'd512, "R7 final count", 128'(bytes_done), 128'(57'(cnt) * 57'd512));
    chk(wr_valid == 1'b0, "R6 valid low after last", 128'(wr_valid), 0);
    exp_q.delete();
  endtask

  task automatic do_read(input logic [2:0] p, input logic [47:0] sec, input logic [47:0] cnt,
                         input int bad, input int bad2);
    logic [127:0] q[$];
    int words;
    words = int'(cnt) * 32;
    build(p, sec, words, q);
    issue(1, p, sec, cnt);
    chk(rd_ready == 1'b1 && wr_valid == 1'b0, "R11 read mode ready", 128'({rd_ready, wr_valid}), 128'(2));
    for (int k = 0; k < words; k++) begin
      if (k % 5 == 3) begin
        rd_valid = 1'b0;
        @(negedge clk);
      end
      if (k == 10) chk(bytes_done == 57'd160, "R7 count mid read", 128'(bytes_done), 128'(160));
      rd_valid = 1'b1;
      rd_data = (k == bad) ? (q[k] ^ 128'hF0) : (k == bad2) ? ~q[k] : q[k];
      @(negedge clk);
    end
    rd_valid = 1'b0;
    chk(busy == 1'b0 && rd_ready == 1'b0, "R6 read ends", 128'({busy, rd_ready}), 0);
    if (bad < 0) begin
      chk(verify_fail == 1'b0, "R5 clean read", 128'(verify_fail), 0);
    end else begin
      chk(verify_fail == 1'b1, "R8 fail raised", 128'(verify_fail), 128'(1));
      chk(fail_exp == q[bad], "R9 expected snapshot", fail_exp, q[bad]);
      chk(fail_got == (q[bad] ^ 128'hF0), "R9 received snapshot", fail_got, q[bad] ^ 128'hF0);
      chk(fail_byte_addr == {sec, 9'b0} + 57'(16 * bad), "R9 byte address",
          128'(fail_byte_addr), 128'({sec, 9'b0} + 57'(16 * bad)));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 0 && wr_valid == 0 && rd_ready == 0 && verify_fail == 0 && bytes_done == 0,
        "R13 reset state", 128'({busy, wr_valid, rd_ready, verify_fail, bytes_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && bytes_done == 0, "R13 idle after reset", 128'({busy, bytes_done}), 0);

    do_write("R1", 3'b000, 48'd5, 48'd1, 1, 0);
    do_write("R2", 3'b001, 48'h0000_0123_4567, 48'd1, 0, 0);
    do_write("R3", 3'b010, 48'd9, 48'd1, 1, 0);
    do_write("R3", 3'b011, 48'd9, 48'd1, 0, 0);
    do_write("R3", 3'b110, 48'd2, 48'd1, 0, 0);
    do_write("R4", 3'b100, 48'h0000_1234_5678, 48'd2, 1, 0);
    do_write("R12", 3'b000, 48'd40, 48'd1, 1, 1);

    do_read(3'b100, 48'h0000_1234_5678, 48'd2, -1, -1);  // R5
    do_read(3'b000, 48'd300, 48'd1, 7, 20);               // R8 R9

    @(negedge clk);
    chk(verify_fail == 1'b1, "R8 still set while idle", 128'(verify_fail), 128'(1));
    issue(0, 3'b000, 48'd1, 48'd0);                       // R10 with zero length
    chk(verify_fail == 0 && fail_exp == 0 && fail_got == 0 && fail_byte_addr == 0,
        "R10 clear on command", 128'({verify_fail, fail_byte_addr}), 0);
    chk(busy == 0 && wr_valid == 0, "R6 zero length idle", 128'({busy, wr_valid}), 0);

    do_read(3'b001, 48'd3, 48'd1, 31, -1);                // R9 last word
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule